// File: doc/BRIEF.md
# I2C Slave Address Comparator

This block is the address-recognition stage of an I2C target. It holds an 8-bit address register that the host CPU programs. It compares that register with the first byte that arrives after each START condition. Byte assembly, START and STOP detection are done elsewhere and reach this block as single-cycle pulses. The block reports whether the bus master has addressed this target and which transfer direction it asked for.

Two addressing modes are supported. In 7-bit mode only the seven address bits are compared. In 10-bit mode the block checks the first address byte in full: it matches the seven stored address bits together with the stored direction bit against all eight received bits. The stored direction bit clears itself whenever a STOP is seen. Register writes that arrive while a comparison is pending are held back until that comparison has finished.

Top module: `i2c_addr_cmp`

## Requirements
- R1: After reset `cfg_rdata` reads 0x00 and both `addr_match` and `rx_dir` are 0.
- R2: A register write (`cpu_we`) made while no comparison is pending appears on `cfg_rdata` one cycle later. Bits 7..1 hold the slave address and bit 0 holds the stored direction bit.
- R3: With `ten_bit_mode` = 0, a first byte matches when its bits 7..1 equal register bits 7..1. Register bit 0 and received bit 0 take no part in the compare.
- R4: With `ten_bit_mode` = 1, a first byte matches only when all 8 bits equal the full register, stored direction bit included.
- R5: Only the first `rx_valid` byte after a START is compared. Later bytes, and bytes arriving with no START since the last compare or STOP, leave `addr_match` and `rx_dir` unchanged.
- R6: A START, including a repeated START, clears `addr_match` and `rx_dir` in the next cycle and re-arms the compare for the next byte.
- R7: A STOP clears `addr_match`, `rx_dir` and register bit 0 in the next cycle. This holds even when a register write lands in the same cycle, whose bits 7..1 still take effect.
- R8: On a match, `rx_dir` takes bit 0 of the matching byte (1 = read, 0 = write). Otherwise `rx_dir` stays 0.
- R9: A register write made while a compare is pending does not affect that compare. It lands on the register in the cycle after the compare (or STOP) ends.
- R10: If START and `rx_valid` coincide, the byte is ignored and the compare stays armed. If STOP and `rx_valid` coincide, the byte is ignored and no match is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_det | input | 1 | One-cycle pulse: STOP seen |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, MSB first on the bus |
| ten_bit_mode | input | 1 | 0 = 7-bit addressing, 1 = 10-bit first-byte addressing |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Current register contents |
| addr_match | output | 1 | Target addressed in the current transaction |
| rx_dir | output | 1 | Direction bit of the matching address byte |

## Verification
Two pairs of events can collide in a single cycle. The first pair is a CPU write and a byte compare. The bench drives `cpu_we` with new data in the same cycle as the first address byte. It judges the result by the match outcome, which must follow the old address, and by `cfg_rdata`, which must show the new value only one cycle later. The second pair is STOP against a register write or a received byte: the bench pulses them together and checks that bit 0 reads back as 0 and that no match is raised.

// File: rtl/i2c_addr_cmp.sv
module i2c_addr_cmp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_det,
  input  logic         stop_det,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic         ten_bit_mode,
  input  logic         cpu_we,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cfg_rdata,
  output logic         addr_match,
  output logic         rx_dir
);

  logic [W-1:0] areg, pend_d, eff_d;
  logic         armed, pend_v, eff_we, hit, take;

  assign cfg_rdata = areg;
  assign eff_we    = (cpu_we | pend_v) & ~armed;
  assign eff_d     = cpu_we ? cpu_wdata : pend_d;
  assign hit       = ten_bit_mode ? (rx_byte == areg) : (rx_byte[W-1:1] == areg[W-1:1]);
  assign take      = rx_valid & armed & ~start_det & ~stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (start_det) begin
      armed <= 1'b1;
    end else if (stop_det | rx_valid) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (cpu_we & armed) begin
      pend_v <= 1'b1;
      pend_d <= cpu_wdata;
    end else if (!armed) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      areg <= '0;
    end else if (eff_we) begin
      areg <= {eff_d[W-1:1], eff_d[0] & ~stop_det};
    end else if (stop_det) begin
      areg[0] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_match <= 1'b0;
      rx_dir     <= 1'b0;
    end else if (start_det | stop_det) begin
      addr_match <= 1'b0;
      rx_dir     <= 1'b0;
    end else if (take) begin
      addr_match <= hit;
      rx_dir     <= hit & rx_byte[0];
    end
  end

  // R6
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !addr_match && !rx_dir);

  // R7
  stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !addr_match && !cfg_rdata[0]);

  // R5
  only_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !armed && !start_det && !stop_det) |=> $stable(addr_match) && $stable(rx_dir));

  // R8
  dir_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_match |-> !rx_dir);

  // R9
  write_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && armed) |=> $stable(cfg_rdata[W-1:1]));

  // R2
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && !armed) |=> cfg_rdata[W-1:1] == $past(cpu_wdata[W-1:1]));

  // R4
  ten_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ten_bit_mode && rx_byte != cfg_rdata) |=> !addr_match);

endmodule

// File: tb/i2c_addr_cmp_tb.sv
module i2c_addr_cmp_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_det = 0, stop_det = 0, rx_valid = 0, ten_bit_mode = 0, cpu_we = 0;
  logic [7:0] rx_byte = '0, cpu_wdata = '0, cfg_rdata;
  logic addr_match, rx_dir;

  int checks = 0, errors = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_addr_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .ten_bit_mode(ten_bit_mode),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cfg_rdata(cfg_rdata),
    .addr_match(addr_match), .rx_dir(rx_dir)
  );

  task automatic step(input bit st, input bit sp, input bit v, input logic [7:0] b,
                      input bit we, input logic [7:0] wd,
                      input bit em, input bit ed, input logic [7:0] ec, input string tag);
    @(negedge clk);
    start_det = st; stop_det = sp; rx_valid = v; rx_byte = b;
    cpu_we = we; cpu_wdata = wd;
    exp_q.push_back({em, ed, ec});
    tag_q.push_back(tag);
    @(negedge clk);
    start_det = 0; stop_det = 0; rx_valid = 0; cpu_we = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        logic [9:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({addr_match, rx_dir, cfg_rdata} !== e) begin
          errors++;
          $display("FAIL %s: match/dir/cfg = %b/%b/%h expected %b/%b/%h",
                   t, addr_match, rx_dir, cfg_rdata, e[9], e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    //    st sp v  byte   we wdata  m  d  cfg
    step(0, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'h00, "R1 reset");
    step(0, 0, 0, 8'h00, 1, 8'hA5, 0, 0, 8'hA5, "R2 idle write");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA5, "R6 start");
    step(0, 0, 1, 8'hA4, 0, 8'h00, 1, 0, 8'hA5, "R3 7-bit match ignores bit0");
    step(0, 0, 1, 8'h00, 0, 8'h00, 1, 0, 8'hA5, "R5 later byte ignored");
    step(0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA4, "R7 stop clears");
    step(0, 0, 0, 8'h00, 1, 8'hA5, 0, 0, 8'hA5, "R2 rewrite");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA5, "R6 start");
    step(0, 0, 1, 8'hA5, 0, 8'h00, 1, 1, 8'hA5, "R8 dir read");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA5, "R6 repeated start clears");
    step(0, 0, 1, 8'h12, 0, 8'h00, 0, 0, 8'hA5, "R3 mismatch");
    step(0, 0, 1, 8'hA5, 0, 8'h00, 0, 0, 8'hA5, "R5 second byte ignored");
    ten_bit_mode = 1;
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA5, "R6 start");
    step(0, 0, 1, 8'hA5, 0, 8'h00, 1, 1, 8'hA5, "R4 10-bit match");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA5, "R6 start");
    step(0, 0, 1, 8'hA4, 0, 8'h00, 0, 0, 8'hA5, "R4 bit0 differs");
    step(0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA4, "R7 stop clears bit0");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA4, "R6 start");
    step(0, 0, 1, 8'hA5, 0, 8'h00, 0, 0, 8'hA4, "R7 cleared bit0 used");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA4, "R6 start");
    step(0, 0, 1, 8'hA4, 0, 8'h00, 1, 0, 8'hA4, "R4 10-bit match write dir");
    step(0, 1, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA4, "R7 stop");
    step(0, 0, 0, 8'h00, 1, 8'hA5, 0, 0, 8'hA5, "R2 write");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'hA5, "R6 start");
    step(0, 0, 1, 8'hA5, 1, 8'h3C, 1, 1, 8'hA5, "R9 write with compare");
    step(0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 8'h3C, "R9 write lands after");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'h3C, "R6 start");
    step(0, 0, 0, 8'h00, 1, 8'h11, 0, 0, 8'h3C, "R9 write held while armed");
    step(0, 0, 1, 8'h3C, 0, 8'h00, 1, 0, 8'h3C, "R9 old address compared");
    step(0, 0, 0, 8'h00, 0, 8'h00, 1, 0, 8'h11, "R9 held write lands");
    step(0, 1, 0, 8'h00, 1, 8'h81, 0, 0, 8'h80, "R7 stop beats write bit0");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'h80, "R6 start");
    step(1, 0, 1, 8'h80, 0, 8'h00, 0, 0, 8'h80, "R10 start with byte");
    step(0, 0, 1, 8'h80, 0, 8'h00, 1, 0, 8'h80, "R10 still armed");
    step(1, 0, 0, 8'h00, 0, 8'h00, 0, 0, 8'h80, "R6 start");
    step(0, 1, 1, 8'h80, 0, 8'h00, 0, 0, 8'h80, "R10 stop with byte");
    step(0, 0, 1, 8'h80, 0, 8'h00, 0, 0, 8'h80, "R5 no start no compare");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule